// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the even parity bit of a multiplexed 32-bit address/data bus and its 4-bit command/byte-enable bus. The parity covers all 36 bits. When the device owns the bus, it registers the parity of each address phase and each completed data phase and drives it, with an output enable, on the following clock. When another agent owns the bus, the block keeps the parity it computed for the phase. One clock later it compares that value with the parity bit the initiator supplies.

A data-phase mismatch produces a one-clock parity-error pulse, but only while the parity-error enable of the command register is set. An address-phase mismatch is reported only on the system-error output. An address parity error flagged by the card-side bus also goes to that output. System error is a one-clock pulse per event and is gated by its own command-register enable. A sticky detection flag records every mismatch whatever the enables are. Software clears it by writing 1 to it. Transaction sequencing and configuration decoding sit outside the block: phase strobes, the command register value and the status write arrive as inputs.

Top module: `pci_parity_unit`

## Requirements
- R1: When `parOe` is high, `parOut` equals the XOR of all 32 bits of `ad` and all 4 bits of `cbe` sampled on the previous clock, so the 37 bits together have even parity. Byte enable i belongs to byte lane i, which is bits 8i+7..8i.
- R2: `parOe` is high for exactly the cycle after a clock edge at which `isInitiator` is high and either `addrPhase` is high or a data phase completes (`irdy` and `trdy` both high). At all other times it is low.
- R3: A data phase that completes at edge t with `isInitiator` low and `addrPhase` low is checked against `parIn` sampled at edge t+1. On a mismatch, `perrOut` is high for the one cycle after edge t+1.
- R4: `perrOut` is never high unless `cmdReg[6]` was high at the checking edge.
- R5: An address phase at edge t with `isInitiator` low whose parity mismatches `parIn` at edge t+1 raises `serrOut` for the one cycle after t+1, provided `cmdReg[8]` is high at t+1.
- R6: `cardAddrPerr` high at an edge raises `serrOut` for the following cycle when `cmdReg[8]` is high at that edge. With `cmdReg[8]` low, `serrOut` stays low.
- R7: An address-phase parity mismatch never raises `perrOut`.
- R8: `parErrDetected` goes high after any checked mismatch (data or address), whatever the enables. It stays high until an edge with `statWr` and `statWrData` both high and no new mismatch. A new mismatch wins over a clear in the same cycle.
- R9: After reset, `parOe`, `perrOut`, `serrOut` and `parErrDetected` are low.
- R10: A data phase with `irdy` high and `trdy` low (a wait state) is not checked and does not drive parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ad | input | 32 | Address/data bus value |
| cbe | input | 4 | Command/byte-enable bus value |
| parIn | input | 1 | Parity bit received from the bus |
| isInitiator | input | 1 | High when this device owns the transaction |
| addrPhase | input | 1 | Address phase strobe |
| irdy | input | 1 | Initiator ready, active high |
| trdy | input | 1 | Target ready, active high |
| cmdReg | input | 16 | Command register; bit 6 enables parity error, bit 8 enables system error |
| cardAddrPerr | input | 1 | Address parity error detected on the card-side bus |
| statWr | input | 1 | Status write strobe |
| statWrData | input | 1 | Write data for the detection flag (1 clears) |
| parOut | output | 1 | Generated parity bit |
| parOe | output | 1 | Drive enable for `parOut` |
| perrOut | output | 1 | Data parity error pulse, active high |
| serrOut | output | 1 | System error pulse, active high |
| parErrDetected | output | 1 | Sticky parity-error detection flag |

## Verification
The assertions take for granted that `addrPhase` and a completed data phase never fall in the same cycle. They also assume that all inputs change only away from the clock edge. The stimulus forces `irdy` low in every address-phase cycle and drives every input on the falling edge. `parIn` is random in general. In the cycle after a target phase it is chosen, with a fixed bias, as either the correct or the inverted parity, so that both matches and mismatches reach the checker under every mix of enables.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // Kind of check pending for the clock after a target-side phase
  typedef enum logic [1:0] {
    CHK_NONE = 2'd0,
    CHK_DATA = 2'd1,
    CHK_ADDR = 2'd2
  } chkKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // hold computed parity for a later compare
    logic drive;    // load the outgoing parity register
  } parStrobe_t;

endpackage

// File: rtl/pci_par_datapath.sv
module pci_par_datapath
  import pci_par_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] ad,
  input  logic [LANES-1:0]  cbe,
  input  logic              parIn,
  input  parStrobe_t        strobe,
  output logic              parOut,
  output logic              mismatch
);

  logic [LANES-1:0] lanePar;
  logic             busPar;
  logic             expPar;

  // One parity term per byte lane, including its own enable bit
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanePar[g] = (^ad[g*LANE_W +: LANE_W]) ^ cbe[g];
    end
  endgenerate

  assign busPar = ^lanePar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expPar <= 1'b0;
      parOut <= 1'b0;
    end else begin
      if (strobe.capture) expPar <= busPar;
      if (strobe.drive)   parOut <= busPar;
    end
  end

  assign mismatch = expPar ^ parIn;

endmodule

// File: rtl/pci_par_ctrl.sv
module pci_par_ctrl
  import pci_par_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       isInitiator,
  input  logic       addrPhase,
  input  logic       irdy,
  input  logic       trdy,
  input  logic       perrEn,
  input  logic       serrEn,
  input  logic       cardAddrPerr,
  input  logic       statWr,
  input  logic       statWrData,
  input  logic       mismatch,
  output parStrobe_t strobe,
  output logic       parOe,
  output logic       perrOut,
  output logic       serrOut,
  output logic       parErrDetected
);

  logic     xferDone;
  logic     phaseSeen;
  chkKind_t chkNext;
  chkKind_t chkPend;
  logic     dataBad;
  logic     addrBad;

  assign xferDone  = irdy & trdy;
  assign phaseSeen = addrPhase | xferDone;

  always_comb begin
    chkNext = CHK_NONE;
    if (!isInitiator) begin
      if (addrPhase)     chkNext = CHK_ADDR;
      else if (xferDone) chkNext = CHK_DATA;
    end
  end

  assign strobe.drive   = isInitiator & phaseSeen;
  assign strobe.capture = (chkNext != CHK_NONE);

  assign dataBad = (chkPend == CHK_DATA) & mismatch;
  assign addrBad = (chkPend == CHK_ADDR) & mismatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkPend        <= CHK_NONE;
      parOe          <= 1'b0;
      perrOut        <= 1'b0;
      serrOut        <= 1'b0;
      parErrDetected <= 1'b0;
    end else begin
      chkPend <= chkNext;
      parOe   <= strobe.drive;
      perrOut <= dataBad & perrEn;
      serrOut <= (addrBad | cardAddrPerr) & serrEn;
      if (dataBad | addrBad)         parErrDetected <= 1'b1;
      else if (statWr && statWrData) parErrDetected <= 1'b0;
    end
  end

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int CMD_W       = 16,
  parameter int PERR_EN_BIT = 6,
  parameter int SERR_EN_BIT = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] ad,
  input  logic [LANES-1:0]  cbe,
  input  logic              parIn,
  input  logic              isInitiator,
  input  logic              addrPhase,
  input  logic              irdy,
  input  logic              trdy,
  input  logic [CMD_W-1:0]  cmdReg,
  input  logic              cardAddrPerr,
  input  logic              statWr,
  input  logic              statWrData,
  output logic              parOut,
  output logic              parOe,
  output logic              perrOut,
  output logic              serrOut,
  output logic              parErrDetected
);

  parStrobe_t strobe;
  logic       mismatch;

  pci_par_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ad       (ad),
    .cbe      (cbe),
    .parIn    (parIn),
    .strobe   (strobe),
    .parOut   (parOut),
    .mismatch (mismatch)
  );

  pci_par_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .isInitiator    (isInitiator),
    .addrPhase      (addrPhase),
    .irdy           (irdy),
    .trdy           (trdy),
    .perrEn         (cmdReg[PERR_EN_BIT]),
    .serrEn         (cmdReg[SERR_EN_BIT]),
    .cardAddrPerr   (cardAddrPerr),
    .statWr         (statWr),
    .statWrData     (statWrData),
    .mismatch       (mismatch),
    .strobe         (strobe),
    .parOe          (parOe),
    .perrOut        (perrOut),
    .serrOut        (serrOut),
    .parErrDetected (parErrDetected)
  );

endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
  parameter int DATA_W      = 32,
  parameter int LANES       = 4,
  parameter int CMD_W       = 16,
  parameter int PERR_EN_BIT = 6,
  parameter int SERR_EN_BIT = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] ad,
  input logic [LANES-1:0]  cbe,
  input logic              isInitiator,
  input logic              addrPhase,
  input logic              irdy,
  input logic              trdy,
  input logic [CMD_W-1:0]  cmdReg,
  input logic              cardAddrPerr,
  input logic              parOut,
  input logic              parOe,
  input logic              perrOut,
  input logic              serrOut,
  input logic              parErrDetected
);

  p_even_parity_r1: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> (parOut == ^{$past(ad), $past(cbe)}));

  p_oe_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> $past(isInitiator && (addrPhase || (irdy && trdy))));

  p_perr_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    perrOut |-> $past(!isInitiator && !addrPhase && irdy && trdy, 2));

  p_perr_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    perrOut |-> $past(cmdReg[PERR_EN_BIT]));

  p_serr_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    serrOut |-> $past(cmdReg[SERR_EN_BIT]));

  p_serr_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    serrOut |-> ($past(cardAddrPerr) || $past(addrPhase && !isInitiator, 2)));

  p_sticky_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    perrOut |-> parErrDetected);

endmodule

bind pci_parity_unit pci_parity_unit_chk #(
  .DATA_W(DATA_W), .LANES(LANES), .CMD_W(CMD_W),
  .PERR_EN_BIT(PERR_EN_BIT), .SERR_EN_BIT(SERR_EN_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .ad(ad), .cbe(cbe),
  .isInitiator(isInitiator), .addrPhase(addrPhase),
  .irdy(irdy), .trdy(trdy), .cmdReg(cmdReg),
  .cardAddrPerr(cardAddrPerr), .parOut(parOut), .parOe(parOe),
  .perrOut(perrOut), .serrOut(serrOut), .parErrDetected(parErrDetected)
);

// File: tb/tb_pci_parity_unit.sv
module tb_pci_parity_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic        parIn;
  logic        isInitiator;
  logic        addrPhase;
  logic        irdy;
  logic        trdy;
  logic [15:0] cmdReg;
  logic        cardAddrPerr;
  logic        statWr;
  logic        statWrData;
  logic        parOut, parOe, perrOut, serrOut, parErrDetected;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  int   mKind = 0;  // 0 none, 1 data check, 2 address check
  logic mExpPar = 0, mParOut = 0, mParOe = 0, mPerr = 0, mSerr = 0, mSticky = 0;

  always #2 clk = ~clk;

  pci_parity_unit dut (
    .clk(clk), .rstN(rstN), .ad(ad), .cbe(cbe), .parIn(parIn),
    .isInitiator(isInitiator), .addrPhase(addrPhase), .irdy(irdy), .trdy(trdy),
    .cmdReg(cmdReg), .cardAddrPerr(cardAddrPerr), .statWr(statWr),
    .statWrData(statWrData), .parOut(parOut), .parOe(parOe),
    .perrOut(perrOut), .serrOut(serrOut), .parErrDetected(parErrDetected)
  );

  function automatic logic evenPar(input logic [31:0] d, input logic [3:0] c);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += d[i];
    for (int i = 0; i < 4; i++) ones += c[i];
    return logic'(ones % 2);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleInputs();
    ad = '0; cbe = '0; parIn = 0; isInitiator = 0; addrPhase = 0;
    irdy = 0; trdy = 0; cmdReg = '0; cardAddrPerr = 0; statWr = 0; statWrData = 0;
  endtask

  // Called at a falling edge with inputs set; advances one clock and checks
  task automatic step();
    logic mm, p, nPerr, nSerr, nSticky;
    mm = mExpPar ^ parIn;
    p  = evenPar(ad, cbe);
    nPerr = (mKind == 1) && mm && cmdReg[6];
    nSerr = (((mKind == 2) && mm) || cardAddrPerr) && cmdReg[8];
    nSticky = mSticky;
    if ((mKind != 0) && mm) nSticky = 1;
    else if (statWr && statWrData) nSticky = 0;
    mPerr = nPerr; mSerr = nSerr; mSticky = nSticky;
    mParOe = isInitiator && (addrPhase || (irdy && trdy));
    if (mParOe) mParOut = p;
    if (isInitiator) mKind = 0;
    else if (addrPhase) mKind = 2;
    else if (irdy && trdy) mKind = 1;
    else mKind = 0;
    if (mKind != 0) mExpPar = p;
    @(posedge clk);
    @(negedge clk);
    chk("R2 parOe", parOe, mParOe);
    if (mParOe) chk("R1 parOut", parOut, mParOut);
    chk("R3 perrOut", perrOut, mPerr);
    chk("R5 serrOut", serrOut, mSerr);
    chk("R8 parErrDetected", parErrDetected, mSticky);
  endtask

  task automatic targetPhase(input bit isAddr, input logic [31:0] d, input logic [3:0] c);
    idleInputs();
    ad = d; cbe = c; addrPhase = isAddr; irdy = !isAddr; trdy = !isAddr;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R9 parOe reset", parOe, 0);
    chk("R9 perrOut reset", perrOut, 0);
    chk("R9 serrOut reset", serrOut, 0);
    chk("R9 parErrDetected reset", parErrDetected, 0);

    // R1/R2 directed: initiator address then data phase, all ones bus
    idleInputs(); isInitiator = 1; addrPhase = 1; ad = '1; cbe = 4'hF; step();
    chk("R1 all ones parity", parOut, 0);
    idleInputs(); isInitiator = 1; irdy = 1; trdy = 1; ad = 32'h0000_0001; cbe = 4'h0; step();
    chk("R1 single bit parity", parOut, 1);

    // R4: data mismatch with parity-error enable off
    targetPhase(0, 32'h1234_5678, 4'h3);
    idleInputs(); parIn = ~mExpPar; step();
    chk("R4 perr gated", perrOut, 0);
    chk("R8 set without enable", parErrDetected, 1);
    idleInputs(); statWr = 1; statWrData = 1; step();
    chk("R8 cleared by write one", parErrDetected, 0);

    // R7/R5: address mismatch with both enables on
    targetPhase(1, 32'hDEAD_BEEF, 4'h6);
    idleInputs(); cmdReg[6] = 1; cmdReg[8] = 1; parIn = ~mExpPar; step();
    chk("R7 no perr on address", perrOut, 0);
    chk("R5 serr on address", serrOut, 1);
    idleInputs(); step();
    chk("R5 serr single pulse", serrOut, 0);

    // R8: new mismatch wins over clear in the same cycle
    targetPhase(0, 32'h0F0F_0F0F, 4'h1);
    idleInputs(); parIn = ~mExpPar; statWr = 1; statWrData = 1; cmdReg[6] = 1; step();
    chk("R8 set beats clear", parErrDetected, 1);
    chk("R3 perr pulse", perrOut, 1);
    idleInputs(); statWr = 1; statWrData = 0; step();
    chk("R8 write zero keeps flag", parErrDetected, 1);
    idleInputs(); statWr = 1; statWrData = 1; step();

    // R10: wait state is not checked and not driven
    idleInputs(); irdy = 1; trdy = 0; ad = 32'hAAAA_0001; step();
    idleInputs(); cmdReg[6] = 1; cmdReg[8] = 1; parIn = ~mExpPar; step();
    chk("R10 wait state perr", perrOut, 0);
    chk("R10 wait state flag", parErrDetected, 0);
    idleInputs(); isInitiator = 1; irdy = 1; trdy = 0; step();
    chk("R10 wait state no drive", parOe, 0);

    // R6: card-side address error
    idleInputs(); cardAddrPerr = 1; cmdReg[8] = 1; step();
    chk("R6 card error serr", serrOut, 1);
    idleInputs(); cardAddrPerr = 1; step();
    chk("R6 card error gated", serrOut, 0);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      logic wasCheck;
      wasCheck = (mKind != 0);
      idleInputs();
      ad = $urandom;
      cbe = 4'($urandom);
      isInitiator = ($urandom % 2) == 0;
      addrPhase = ($urandom % 8) == 0;
      irdy = addrPhase ? 1'b0 : (($urandom % 5) < 3);
      trdy = ($urandom % 5) < 3;
      cmdReg = 16'($urandom);
      cardAddrPerr = ($urandom % 16) == 0;
      statWr = ($urandom % 8) == 0;
      statWrData = $urandom % 2;
      if (wasCheck) parIn = (($urandom % 4) == 0) ? ~mExpPar : mExpPar;
      else parIn = $urandom % 2;
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule